// File: doc/BRIEF.md
# Transmit Timestamp Offset Calibration Sequencer

This block carries out, in hardware, the one-time calibration that a hard Ethernet transmit timestamping path needs before it can run. After any reset it waits for the path to report that its raw offset measurements are valid. It then reads three measurement registers over a simple register master port: constant delay, alignment-pulse offset and wire delay. From these it forms two words. The first is a signed time-alignment correction. The second is a positive extra-latency value, built from the PMA delay and the external PHY delay. It writes both words back, sets the configuration-done bit, and polls a status register until the path reports that it is ready.

The PMA delay arrives in unit intervals (UI). The block converts it to nanoseconds with the UI period, which is given in a 4.28 fixed-point nanosecond format. It then rescales the result to the 16-bit-fraction nanosecond format that every other time quantity uses. A transmit reset at any point discards the run in progress and starts again at the wait for valid offsets.

Top module: `ptp_txcal_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released, `busy_o` is 1, `done_o` is 0 and `req_o` is 0 until `offs_valid_i` is seen high.
- R2: No register access is requested while the block waits and `offs_valid_i` is 0.
- R3: Accesses occur in a fixed order. The reads come first: constant delay (0x10), then pulse offset (0x14), then wire delay (0x18). The writes follow: extra latency (0x20), then alignment correction (0x24), then the configuration word 0x00000001 (bit 0 set) to 0x28. A request holds its address, direction and data unchanged until an `ack_i` pulse completes it, and only one access is open at a time.
- R4: In the constant-delay and pulse-offset words, bit 31 is the sign (1 means negative) and bits 30:0 are the magnitude. The correction word is the two's-complement value of constant delay + pulse offset − wire delay.
- R5: The correction saturates at 0x7FFFFFFF and at 0x80000000 instead of wrapping.
- R6: The extra-latency word has bit 31 equal to 0. Bits 30:0 hold floor(`pma_ui_i` × `ui_period_i` / 2^12) + `phy_delay_i`, saturated at 0x7FFFFFFF.
- R7: Only bits 19:0 of the wire-delay word are used. Its upper bits have no effect, and the value is always subtracted.
- R8: After the configuration write, the status register (0x2C) is read again and again until bit 1 reads 1. At that point `done_o` rises, `busy_o` falls and no further access is made.
- R9: `tx_rst_i` at any point withdraws the open request on the next cycle, clears `done_o`, and restarts the whole sequence from the wait for `offs_valid_i`.
- R10: Once high, `done_o` stays high until `rst_n` or `tx_rst_i` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tx_rst_i | input | 1 | Transmit reset; restarts the sequence |
| offs_valid_i | input | 1 | Raw offset data valid |
| pma_ui_i | input | 16 | PMA delay in UI |
| ui_period_i | input | 32 | UI period, 4.28 ns |
| phy_delay_i | input | 31 | External PHY delay, ns with 16-bit fraction |
| req_o | output | 1 | Register access request |
| we_o | output | 1 | 1 = write, 0 = read |
| addr_o | output | 8 | Register address |
| wdata_o | output | 32 | Write data |
| rdata_i | input | 32 | Read data, valid with ack |
| ack_i | input | 1 | One-cycle access completion |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Calibration complete |

## Verification
The hardest situation to reach from the ports is a transmit reset that lands in the middle of the write-back phase. At that moment a write request is open and a completion may arrive in the very cycle the reset does. The bench watches its bus log and fires the reset once four accesses have completed. It then requires a complete new run that begins with the constant-delay read. Saturation of both sums also needs extreme operands that random values seldom produce, so directed cases with full-scale magnitudes and maximal products sit alongside the random ones.

// File: rtl/ptp_txcal_pkg.sv
package ptp_txcal_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned WIRE_W = 20;
  localparam int unsigned UI_FRAC = 28;
  localparam int unsigned NS_FRAC = 16;
  localparam int unsigned RESCALE = UI_FRAC - NS_FRAC;

  typedef enum logic [3:0] {
    ST_WAIT_VLD,
    ST_RD_CONST,
    ST_RD_OFFS,
    ST_RD_WIRE,
    ST_CALC,
    ST_WR_XLAT,
    ST_WR_TAM,
    ST_WR_CFG,
    ST_RD_STAT,
    ST_DONE
  } seq_state_t;

endpackage

// File: rtl/ptp_txcal_smdec.sv
module ptp_txcal_smdec (
  input  logic [31:0]        raw_i,
  output logic signed [32:0] val_o
);
  logic signed [32:0] mag;

  always_comb begin
    mag   = $signed({2'b00, raw_i[30:0]});
    val_o = raw_i[31] ? -mag : mag;
  end
endmodule

// File: rtl/ptp_txcal_math.sv
module ptp_txcal_math
  import ptp_txcal_pkg::*;
#(
  parameter int unsigned UIW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [31:0]          const_i,
  input  logic [31:0]          offs_i,
  input  logic [WIRE_W-1:0]    wire_i,
  input  logic [UIW-1:0]       pma_ui_i,
  input  logic [31:0]          ui_period_i,
  input  logic [30:0]          phy_i,
  output logic [31:0]          tam_o,
  output logic [31:0]          xlat_o
);
  localparam int unsigned PW  = UIW + 32;
  localparam int unsigned NSW = PW - RESCALE;
  localparam int unsigned XW  = NSW + 1;

  logic [31:0]        sm_raw [2];
  logic signed [32:0] sm_val [2];

  assign sm_raw[0] = const_i;
  assign sm_raw[1] = offs_i;

  for (genvar gi = 0; gi < 2; gi++) begin : g_dec
    ptp_txcal_smdec u_dec (
      .raw_i (sm_raw[gi]),
      .val_o (sm_val[gi])
    );
  end

  logic signed [33:0] tam_sum;
  logic [PW-1:0]      prod;
  logic [NSW-1:0]     pma_ns;
  logic [XW-1:0]      xl_sum;

  always_comb begin
    tam_sum = 34'(sm_val[0]) + 34'(sm_val[1]) - $signed({14'd0, wire_i});
    if (tam_sum > 34'sh0_7FFF_FFFF)
      tam_o = 32'h7FFF_FFFF;
    else if (tam_sum < -34'sh0_8000_0000)
      tam_o = 32'h8000_0000;
    else
      tam_o = tam_sum[31:0];
  end

  always_comb begin
    prod   = PW'(pma_ui_i) * PW'(ui_period_i);
    pma_ns = prod[PW-1:RESCALE];
    xl_sum = XW'(pma_ns) + XW'(phy_i);
    if ((xl_sum >> 31) != '0)
      xlat_o = 32'h7FFF_FFFF;
    else
      xlat_o = {1'b0, xl_sum[30:0]};
  end

  // two non-negative operands minus a wire delay can never saturate to a negative word
  assert_tam_nonneg_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    (!const_i[31] && !offs_i[31] && wire_i == '0) |-> !tam_o[31]);
endmodule

// File: rtl/ptp_txcal_seq.sv
module ptp_txcal_seq
  import ptp_txcal_pkg::*;
#(
  parameter int unsigned AW           = 8,
  parameter int unsigned UIW          = 16,
  parameter logic [AW-1:0] ADDR_CONST = 8'h10,
  parameter logic [AW-1:0] ADDR_OFFS  = 8'h14,
  parameter logic [AW-1:0] ADDR_WIRE  = 8'h18,
  parameter logic [AW-1:0] ADDR_XLAT  = 8'h20,
  parameter logic [AW-1:0] ADDR_TAM   = 8'h24,
  parameter logic [AW-1:0] ADDR_CFG   = 8'h28,
  parameter logic [AW-1:0] ADDR_STAT  = 8'h2C,
  parameter int unsigned CFG_BIT      = 0,
  parameter int unsigned RDY_BIT      = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tx_rst_i,
  input  logic           offs_valid_i,
  input  logic [UIW-1:0] pma_ui_i,
  input  logic [31:0]    ui_period_i,
  input  logic [30:0]    phy_delay_i,
  output logic           req_o,
  output logic           we_o,
  output logic [AW-1:0]  addr_o,
  output logic [31:0]    wdata_o,
  input  logic [31:0]    rdata_i,
  input  logic           ack_i,
  output logic           busy_o,
  output logic           done_o
);
  localparam logic [31:0] CFG_WORD = 32'd1 << CFG_BIT;

  seq_state_t st_q, st_d;
  logic [31:0]       const_q, offs_q, tam_q, xlat_q;
  logic [WIRE_W-1:0] wire_q;
  logic [31:0]       tam_c, xlat_c;
  logic              acc_done;
  logic              en_const, en_offs, en_wire, en_calc;

  ptp_txcal_math #(.UIW(UIW)) u_math (
    .clk         (clk),
    .rst_n       (rst_n),
    .const_i     (const_q),
    .offs_i      (offs_q),
    .wire_i      (wire_q),
    .pma_ui_i    (pma_ui_i),
    .ui_period_i (ui_period_i),
    .phy_i       (phy_delay_i),
    .tam_o       (tam_c),
    .xlat_o      (xlat_c)
  );

  // bus drive decoded from the current state
  always_comb begin
    req_o   = 1'b1;
    we_o    = 1'b0;
    addr_o  = '0;
    wdata_o = '0;
    unique case (st_q)
      ST_RD_CONST: addr_o = ADDR_CONST;
      ST_RD_OFFS:  addr_o = ADDR_OFFS;
      ST_RD_WIRE:  addr_o = ADDR_WIRE;
      ST_WR_XLAT: begin we_o = 1'b1; addr_o = ADDR_XLAT; wdata_o = xlat_q;   end
      ST_WR_TAM:  begin we_o = 1'b1; addr_o = ADDR_TAM;  wdata_o = tam_q;    end
      ST_WR_CFG:  begin we_o = 1'b1; addr_o = ADDR_CFG;  wdata_o = CFG_WORD; end
      ST_RD_STAT:  addr_o = ADDR_STAT;
      default:     req_o = 1'b0;
    endcase
  end

  assign acc_done = req_o && ack_i;
  assign busy_o   = (st_q != ST_DONE);
  assign done_o   = (st_q == ST_DONE);

  // next state
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_WAIT_VLD: if (offs_valid_i) st_d = ST_RD_CONST;
      ST_RD_CONST: if (acc_done) st_d = ST_RD_OFFS;
      ST_RD_OFFS:  if (acc_done) st_d = ST_RD_WIRE;
      ST_RD_WIRE:  if (acc_done) st_d = ST_CALC;
      ST_CALC:     st_d = ST_WR_XLAT;
      ST_WR_XLAT:  if (acc_done) st_d = ST_WR_TAM;
      ST_WR_TAM:   if (acc_done) st_d = ST_WR_CFG;
      ST_WR_CFG:   if (acc_done) st_d = ST_RD_STAT;
      ST_RD_STAT:  if (acc_done && rdata_i[RDY_BIT]) st_d = ST_DONE;
      default:     st_d = st_q;
    endcase
    if (tx_rst_i) st_d = ST_WAIT_VLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_WAIT_VLD;
    else        st_q <= st_d;
  end

  // capture enables
  assign en_const = acc_done && (st_q == ST_RD_CONST) && !tx_rst_i;
  assign en_offs  = acc_done && (st_q == ST_RD_OFFS)  && !tx_rst_i;
  assign en_wire  = acc_done && (st_q == ST_RD_WIRE)  && !tx_rst_i;
  assign en_calc  = (st_q == ST_CALC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      const_q <= '0;
      offs_q  <= '0;
      wire_q  <= '0;
    end else begin
      if (en_const) const_q <= rdata_i;
      if (en_offs)  offs_q  <= rdata_i;
      if (en_wire)  wire_q  <= rdata_i[WIRE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tam_q  <= '0;
      xlat_q <= '0;
    end else if (en_calc) begin
      tam_q  <= tam_c;
      xlat_q <= xlat_c;
    end
  end

  assert_req_hold_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !ack_i && !tx_rst_i) |=>
      (req_o && $stable(addr_o) && $stable(we_o) && $stable(wdata_o)));

  assert_done_quiet_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!req_o && !busy_o));

  assert_txrst_restart_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    tx_rst_i |=> (!req_o && !done_o && busy_o));

  assert_done_hold_R10 : assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !tx_rst_i) |=> done_o);

  assert_wait_valid_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    (!req_o && !done_o && !offs_valid_i && !tx_rst_i && !$past(req_o)) |=> !req_o);
endmodule

// File: tb/ptp_txcal_seq_bench.sv
`timescale 1ns/1ps
module ptp_txcal_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n, tx_rst, offs_valid;
  logic [15:0] pma_ui;
  logic [31:0] ui_period;
  logic [30:0] phy_delay;
  logic        req, we, ack;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata;
  logic        busy, done;

  always #2 clk = ~clk;

  ptp_txcal_seq u_ptp_txcal_seq (
    .clk(clk), .rst_n(rst_n), .tx_rst_i(tx_rst), .offs_valid_i(offs_valid),
    .pma_ui_i(pma_ui), .ui_period_i(ui_period), .phy_delay_i(phy_delay),
    .req_o(req), .we_o(we), .addr_o(addr), .wdata_o(wdata),
    .rdata_i(rdata), .ack_i(ack), .busy_o(busy), .done_o(done)
  );

  int total = 0;
  int bad = 0;

  logic [31:0] r_const, r_offs, r_wire;
  int          polls_needed, stat_reads, wait_cnt;
  logic [7:0]  lg_addr [64];
  logic        lg_we   [64];
  logic [31:0] lg_data [64];
  int          lg_n;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_tam(logic [31:0] c, logic [31:0] o, logic [31:0] w);
    longint sc, so, s;
    sc = c[31] ? -longint'(c[30:0]) : longint'(c[30:0]);
    so = o[31] ? -longint'(o[30:0]) : longint'(o[30:0]);
    s  = sc + so - longint'(w[19:0]);
    if (s > 64'sd2147483647) s = 64'sd2147483647;
    if (s < -64'sd2147483648) s = -64'sd2147483648;
    return s[31:0];
  endfunction

  function automatic logic [31:0] exp_xlat(logic [15:0] p, logic [31:0] u, logic [30:0] f);
    longint t;
    t = ((longint'(p) * longint'(u)) >>> 12) + longint'(f);
    if (t > 64'sd2147483647) t = 64'sd2147483647;
    return {1'b0, t[30:0]};
  endfunction

  // register slave model: random completion delay, one-cycle ack
  initial begin
    ack = 1'b0; rdata = '0; wait_cnt = 0; lg_n = 0; stat_reads = 0;
    forever begin
      @(negedge clk);
      if (ack) begin
        ack = 1'b0;
        wait_cnt = int'($urandom % 3);
      end else if (req) begin
        if (wait_cnt > 0) wait_cnt--;
        else begin
          ack = 1'b1;
          rdata = 32'hDEAD_BEEF;
          if (!we) begin
            case (addr)
              8'h10: rdata = r_const;
              8'h14: rdata = r_offs;
              8'h18: rdata = r_wire;
              8'h2C: begin
                rdata = (stat_reads >= polls_needed) ? 32'h0000_0002 : 32'hFFFF_FFFD;
                stat_reads++;
              end
              default: rdata = 32'h0;
            endcase
          end
          if (lg_n < 64) begin
            lg_addr[lg_n] = addr; lg_we[lg_n] = we; lg_data[lg_n] = wdata;
            lg_n++;
          end
        end
      end
    end
  end

  task automatic wait_done();
    for (int i = 0; i < 3000 && !done; i++) @(negedge clk);
  endtask

  task automatic check_run(input logic [31:0] c, input logic [31:0] o, input logic [31:0] w,
                           input int polls, input string tam_tag);
    int n0;
    chk(done === 1'b1 && busy === 1'b0, "R8", "done/busy after ready", {done, busy}, 2'b10);
    chk(lg_n == 7 + polls, "R8", "access count", lg_n, 7 + polls);
    chk(lg_addr[0] == 8'h10 && !lg_we[0], "R3", "access 0", lg_addr[0], 8'h10);
    chk(lg_addr[1] == 8'h14 && !lg_we[1], "R3", "access 1", lg_addr[1], 8'h14);
    chk(lg_addr[2] == 8'h18 && !lg_we[2], "R3", "access 2", lg_addr[2], 8'h18);
    chk(lg_addr[3] == 8'h20 && lg_we[3], "R3", "access 3", lg_addr[3], 8'h20);
    chk(lg_data[3] == exp_xlat(pma_ui, ui_period, phy_delay), "R6", "extra latency",
        lg_data[3], exp_xlat(pma_ui, ui_period, phy_delay));
    chk(lg_addr[4] == 8'h24 && lg_we[4], "R3", "access 4", lg_addr[4], 8'h24);
    chk(lg_data[4] == exp_tam(c, o, w), tam_tag, "alignment word", lg_data[4], exp_tam(c, o, w));
    chk(lg_addr[5] == 8'h28 && lg_we[5] && lg_data[5] == 32'h1, "R3", "config write",
        lg_data[5], 32'h1);
    for (int k = 6; k < lg_n && k < 64; k++)
      chk(lg_addr[k] == 8'h2C && !lg_we[k], "R8", "status poll", lg_addr[k], 8'h2C);
    n0 = lg_n;
    repeat (8) @(negedge clk);
    chk(lg_n == n0 && done === 1'b1, "R10", "done held, bus quiet", lg_n, n0);
  endtask

  task automatic run_case(input logic [31:0] c, input logic [31:0] o, input logic [31:0] w,
                          input logic [15:0] p, input logic [31:0] u, input logic [30:0] f,
                          input int polls, input string tam_tag);
    @(negedge clk);
    offs_valid = 1'b0;
    r_const = c; r_offs = o; r_wire = w;
    pma_ui = p; ui_period = u; phy_delay = f;
    polls_needed = polls;
    tx_rst = 1'b1;
    @(negedge clk);
    tx_rst = 1'b0;
    chk(done === 1'b0 && busy === 1'b1, "R9", "tx reset clears done", {done, busy}, 2'b01);
    repeat (6) @(negedge clk);
    lg_n = 0; stat_reads = 0;
    repeat (4) @(negedge clk);
    chk(lg_n == 0 && req === 1'b0, "R2", "no access without valid", lg_n, 0);
    offs_valid = 1'b1;
    wait_done();
    check_run(c, o, w, polls, tam_tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; tx_rst = 1'b0; offs_valid = 1'b0;
    pma_ui = '0; ui_period = '0; phy_delay = '0;
    r_const = '0; r_offs = '0; r_wire = '0; polls_needed = 0;
    repeat (3) @(negedge clk);
    chk(busy === 1'b1 && done === 1'b0 && req === 1'b0, "R1", "in reset",
        {busy, done, req}, 3'b100);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(busy === 1'b1 && done === 1'b0 && req === 1'b0, "R1", "after reset",
        {busy, done, req}, 3'b100);
    chk(lg_n == 0, "R2", "no access before valid", lg_n, 0);

    // directed cases
    run_case(32'h0001_0000, 32'h0000_8000, 32'h0000_0100, 16'd40, 32'h0020_0000, 31'h0003_0000, 0, "R4");
    run_case(32'h8005_0000, 32'h0001_2345, 32'h0000_4000, 16'd100, 32'h0160_0000, 31'h0, 2, "R4");
    run_case(32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h0, 16'd1, 32'h1, 31'h0, 1, "R5");
    run_case(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h000F_FFFF, 16'hFFFF, 32'hFFFF_FFFF, 31'h7FFF_FFFF, 0, "R5");
    run_case(32'h0000_1000, 32'h8000_0000, 32'hFFF0_0010, 16'd7, 32'h0333_3333, 31'h10, 1, "R7");

    // transmit reset while the write-back is under way
    @(negedge clk);
    offs_valid = 1'b0; tx_rst = 1'b1; polls_needed = 1;
    r_const = 32'h0000_2000; r_offs = 32'h8000_0800; r_wire = 32'h33;
    @(negedge clk);
    tx_rst = 1'b0; lg_n = 0; stat_reads = 0;
    offs_valid = 1'b1;
    for (int i = 0; i < 500 && lg_n < 4; i++) @(negedge clk);
    tx_rst = 1'b1;
    @(negedge clk);
    chk(req === 1'b0 && done === 1'b0, "R9", "request withdrawn", req, 0);
    tx_rst = 1'b0; lg_n = 0; stat_reads = 0;
    wait_done();
    check_run(r_const, r_offs, r_wire, 1, "R9");

    // random cases
    for (int t = 0; t < 10; t++) begin
      logic [31:0] rc, ro, rw, ru;
      logic [15:0] rp;
      logic [30:0] rf;
      rc = $urandom; ro = $urandom; rw = $urandom;
      rp = 16'($urandom); ru = $urandom >> ($urandom % 6);
      rf = 31'($urandom % 32'h0100_0000);
      run_case(rc, ro, rw, rp, ru, rf, int'($urandom % 4), "R4");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule